// File: doc/BRIEF.md
# Sigma-Delta Decimation Filter with Post-Integrator

This block turns a 1-bit sigma-delta bitstream into signed multi-bit samples. Each accepted bit counts as +1 when it is high and as -1 when it is low. The bits pass through a recursive sinc low-pass filter that decimates them. The sinc order is chosen at run time. A second stage then adds up a programmable number of consecutive filter outputs and produces one final sample from that sum.

The final sample is limited to 24 signed bits and placed in the upper part of a 32-bit word. A 3-bit channel tag sits in the bottom bits of the same word. Each new word comes with a one-cycle end-of-conversion pulse. A sticky overrun flag records any result that replaced an earlier one which had not been acknowledged. Configuration is meant to change only while the enable is low. Dropping the enable clears the whole filtering pipeline.

Top module: `sincf_core`

## Requirements
- R1: After reset, `out_word`, `eoc` and `ovr` are all zero.
- R2: With order code 1 (first-order sinc), filter ratio field F and integrator field 0, result r equals the sum of accepted bits (r-1)(F+1)+1 through r(F+1), each weighted +1 for a one and -1 for a zero.
- R3: Order codes 2 to 5 give the response of that many cascaded (F+1)-tap moving sums. The sums are taken over all bits accepted since enable, with bits before enable counted as zero. Code 0 (fast mode) gives the second-order response. Codes 6 and 7 give the fifth-order response.
- R4: Each final result is the sum of I+1 consecutive filter outputs, where I is the integrator field. One result appears per (F+1)(I+1) accepted bits.
- R5: A cycle with `bit_vld` low changes neither the filter nor the result timing, whatever `bit_in` carries.
- R6: `out_word` holds the 24-bit result in bits 31:8, zeros in bits 7:3, and in bits 2:0 the channel tag present on the cycle the final bit was accepted.
- R7: A sum above 8388607 is delivered as 8388607, and a sum below -8388608 is delivered as -8388608.
- R8: `eoc` is high for the single cycle that follows the clock edge which accepted the final bit of a result, and `out_word` changes on that same edge.
- R9: `ovr` rises together with `eoc` when the previous result has had no `rd_ack` since its own `eoc`. A `rd_ack` sampled on the same edge as the new result counts as read.
- R10: `ovr` stays high until `ovr_clr` is sampled high. If a new overrun occurs on the same edge as the clear, the overrun wins.
- R11: While `cfg_en` is low no result is produced. After it is raised again, filtering restarts from a cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enable; low clears the filtering pipeline |
| cfg_order | input | 3 | Order code: 0 fast mode, 1..5 sinc order |
| cfg_fosr | input | 10 | Filter decimation ratio minus one |
| cfg_iosr | input | 8 | Integrator length minus one |
| cfg_chan | input | 3 | Channel tag packed into the result word |
| bit_vld | input | 1 | Input bit strobe |
| bit_in | input | 1 | Sigma-delta data bit |
| rd_ack | input | 1 | Marks the current result as read |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| out_word | output | 32 | Packed result word |
| eoc | output | 1 | End-of-conversion pulse |
| ovr | output | 1 | Sticky overrun flag |

## Verification
A result is due on the clock edge that accepts its final valid bit. From that edge `eoc`, `out_word` and any new overrun are visible, and `ovr_clr` takes effect on the next edge. The bench drives inputs on the falling edge and keeps an expectation for the coming rising edge. It compares `eoc`, `ovr` and, when a result is due, `out_word` at the falling edge that follows. The expected values come from a direct convolution of the bit history with a bench-built moving-sum kernel, followed by a plain sum and clamp. No recursive arithmetic is involved.

// File: rtl/sincf_pkg.sv
package sincf_pkg;

    localparam int ORD_CODE_W = 3;

    // Number of active integrator/comb pairs for an order code.
    function automatic int stage_count(input logic [ORD_CODE_W-1:0] code, input int omax);
        int n;
        if (code == '0)
            n = 2;
        else if (int'(code) > omax)
            n = omax;
        else
            n = int'(code);
        return n;
    endfunction

endpackage

// File: rtl/sincf_cic.sv
module sincf_cic
    import sincf_pkg::*;
#(
    parameter int ORD_MAX = 5,
    parameter int FOSR_W  = 10,
    parameter int CIC_W   = 1 + ORD_MAX * FOSR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [ORD_CODE_W-1:0] order_code,
    input  logic [FOSR_W-1:0]     fosr,
    input  logic                  bit_vld,
    input  logic                  bit_in,
    output logic                  flt_vld,
    output logic [CIC_W-1:0]      flt_out
);

    typedef struct packed {
        logic [ORD_MAX-1:0][CIC_W-1:0] integ;
        logic [ORD_MAX-1:0][CIC_W-1:0] dly;
        logic [FOSR_W-1:0]             cnt;
    } cic_st_t;

    cic_st_t          st_d, st_q;
    logic [CIC_W-1:0] step, run, tap, cpath;
    logic             hit;
    int               nst;

    assign step = bit_in ? CIC_W'(1) : {CIC_W{1'b1}};

    always_comb begin
        st_d = st_q;
        nst  = stage_count(order_code, ORD_MAX);
        hit  = bit_vld && (st_q.cnt == fosr);

        // integrator chain at the bit rate
        run = step;
        tap = '0;
        for (int k = 0; k < ORD_MAX; k++) begin
            run = st_q.integ[k] + run;
            if (bit_vld)
                st_d.integ[k] = run;
            if (k == nst - 1)
                tap = run;
        end

        // comb chain at the decimated rate
        cpath = tap;
        for (int k = 0; k < ORD_MAX; k++) begin
            if (k < nst) begin
                if (hit)
                    st_d.dly[k] = cpath;
                cpath = cpath - st_q.dly[k];
            end
        end

        if (bit_vld)
            st_d.cnt = hit ? '0 : FOSR_W'(st_q.cnt + 1'b1);

        if (!en)
            st_d = '0;
    end

    assign flt_vld = en && hit;
    assign flt_out = cpath;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/sincf_accum.sv
module sincf_accum #(
    parameter int CIC_W  = 51,
    parameter int IOSR_W = 8,
    parameter int OUT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [IOSR_W-1:0] iosr,
    input  logic              flt_vld,
    input  logic [CIC_W-1:0]  flt_in,
    output logic              res_vld,
    output logic [OUT_W-1:0]  res_out
);

    localparam int ACC_W = CIC_W + IOSR_W;
    localparam int HI_W  = ACC_W - OUT_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [IOSR_W-1:0] cnt;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W-1:0] sum;
    logic [HI_W-1:0]  hi;

    always_comb begin
        st_d    = st_q;
        sum     = st_q.acc + {{IOSR_W{flt_in[CIC_W-1]}}, flt_in};
        hi      = sum[ACC_W-1:OUT_W-1];
        res_vld = 1'b0;

        // clamp to the signed output range
        if ((&hi) || !(|hi))
            res_out = sum[OUT_W-1:0];
        else if (sum[ACC_W-1])
            res_out = {1'b1, {(OUT_W-1){1'b0}}};
        else
            res_out = {1'b0, {(OUT_W-1){1'b1}}};

        if (flt_vld) begin
            if (st_q.cnt == iosr) begin
                res_vld  = en;
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = sum;
                st_d.cnt = IOSR_W'(st_q.cnt + 1'b1);
            end
        end

        if (!en)
            st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/sincf_result.sv
module sincf_result #(
    parameter int OUT_W = 24,
    parameter int CH_W  = 3,
    parameter int PAD_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic [CH_W-1:0]               chan,
    input  logic                          res_vld,
    input  logic [OUT_W-1:0]              res_in,
    input  logic                          rd_ack,
    input  logic                          ovr_clr,
    output logic [OUT_W+PAD_W+CH_W-1:0]   word,
    output logic                          eoc,
    output logic                          ovr
);

    localparam int WORD_W = OUT_W + PAD_W + CH_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              eoc;
        logic              pend;
        logic              ovr;
    } res_st_t;

    res_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.eoc  = res_vld && en;
        st_d.pend = res_vld || (st_q.pend && !rd_ack);

        if (res_vld)
            st_d.word = {res_in, {PAD_W{1'b0}}, chan};

        if (res_vld && st_q.pend && !rd_ack)
            st_d.ovr = 1'b1;
        else if (ovr_clr)
            st_d.ovr = 1'b0;

        if (!en) begin
            st_d.eoc  = 1'b0;
            st_d.pend = 1'b0;
        end
    end

    assign word = st_q.word;
    assign eoc  = st_q.eoc;
    assign ovr  = st_q.ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/sincf_core.sv
module sincf_core
    import sincf_pkg::*;
#(
    parameter int ORD_MAX = 5,
    parameter int FOSR_W  = 10,
    parameter int IOSR_W  = 8,
    parameter int OUT_W   = 24,
    parameter int CH_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_en,
    input  logic [ORD_CODE_W-1:0]     cfg_order,
    input  logic [FOSR_W-1:0]         cfg_fosr,
    input  logic [IOSR_W-1:0]         cfg_iosr,
    input  logic [CH_W-1:0]           cfg_chan,
    input  logic                      bit_vld,
    input  logic                      bit_in,
    input  logic                      rd_ack,
    input  logic                      ovr_clr,
    output logic [OUT_W+8-1:0]        out_word,
    output logic                      eoc,
    output logic                      ovr
);

    localparam int CIC_W  = 1 + ORD_MAX * FOSR_W;
    localparam int WORD_W = OUT_W + 8;
    localparam int PAD_W  = WORD_W - OUT_W - CH_W;

    logic             flt_vld;
    logic [CIC_W-1:0] flt_val;
    logic             res_vld;
    logic [OUT_W-1:0] res_val;

    sincf_cic #(
        .ORD_MAX (ORD_MAX),
        .FOSR_W  (FOSR_W),
        .CIC_W   (CIC_W)
    ) u_cic (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .order_code (cfg_order),
        .fosr       (cfg_fosr),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .flt_vld    (flt_vld),
        .flt_out    (flt_val)
    );

    sincf_accum #(
        .CIC_W  (CIC_W),
        .IOSR_W (IOSR_W),
        .OUT_W  (OUT_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_en),
        .iosr    (cfg_iosr),
        .flt_vld (flt_vld),
        .flt_in  (flt_val),
        .res_vld (res_vld),
        .res_out (res_val)
    );

    sincf_result #(
        .OUT_W (OUT_W),
        .CH_W  (CH_W),
        .PAD_W (PAD_W)
    ) u_result (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_en),
        .chan    (cfg_chan),
        .res_vld (res_vld),
        .res_in  (res_val),
        .rd_ack  (rd_ack),
        .ovr_clr (ovr_clr),
        .word    (out_word),
        .eoc     (eoc),
        .ovr     (ovr)
    );

endmodule

// File: rtl/sincf_core_chk.sv
module sincf_core_chk #(
    parameter int OUT_W  = 24,
    parameter int CH_W   = 3,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic [CH_W-1:0]   cfg_chan,
    input logic              bit_vld,
    input logic              rd_ack,
    input logic              ovr_clr,
    input logic [WORD_W-1:0] out_word,
    input logic              eoc,
    input logic              ovr
);

    localparam int PAD_HI = WORD_W - OUT_W - 1;

    // R8
    eoc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> $past(bit_vld && cfg_en));

    // R5
    idle_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !eoc);

    // R6
    word_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> (out_word[PAD_HI:CH_W] == '0 && out_word[CH_W-1:0] == $past(cfg_chan)));

    // R9
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> eoc);

    // R10
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    // R10
    ovr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr) |-> $past(ovr_clr));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !eoc);

    // R9
    ack_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !ovr) |=> !ovr || eoc);

endmodule

bind sincf_core sincf_core_chk #(
    .OUT_W  (OUT_W),
    .CH_W   (CH_W),
    .WORD_W (WORD_W)
) u_chk (.*);

// File: tb/sincf_core_test.sv
module sincf_core_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_en;
    logic [2:0]  cfg_order;
    logic [9:0]  cfg_fosr;
    logic [7:0]  cfg_iosr;
    logic [2:0]  cfg_chan;
    logic        bit_vld;
    logic        bit_in;
    logic        rd_ack;
    logic        ovr_clr;
    logic [31:0] out_word;
    logic        eoc;
    logic        ovr;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    longint      h[];
    int          xs[$];
    int          m_r, m_i, m_ch, kbits, nres;
    bit          m_pend, m_ovr, exp_eoc;
    logic [31:0] exp_word;
    string       tag;

    always #4 clk = ~clk;

    sincf_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_order (cfg_order),
        .cfg_fosr  (cfg_fosr),
        .cfg_iosr  (cfg_iosr),
        .cfg_chan  (cfg_chan),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .rd_ack    (rd_ack),
        .ovr_clr   (ovr_clr),
        .out_word  (out_word),
        .eoc       (eoc),
        .ovr       (ovr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_order(input int code);
        if (code == 0) return 2;
        if (code > 5) return 5;
        return code;
    endfunction

    // kernel of n cascaded r-tap moving sums
    task automatic build_kernel(input int n, input int r);
        longint t[];
        h = new[1];
        h[0] = 1;
        repeat (n) begin
            t = new[h.size() + r - 1];
            foreach (t[i]) begin
                t[i] = 0;
                for (int s = 0; s < r; s++)
                    if (i - s >= 0 && i - s < h.size())
                        t[i] += h[i - s];
            end
            h = t;
        end
    endtask

    function automatic longint filt(input int m);
        longint acc = 0;
        for (int j = 0; j < h.size(); j++) begin
            int idx = m * m_r - 1 - j;
            if (idx >= 0)
                acc += h[j] * xs[idx];
        end
        return acc;
    endfunction

    function automatic logic [31:0] exp_result(input int r);
        longint s = 0;
        logic [23:0] v;
        for (int m = (r - 1) * (m_i + 1) + 1; m <= r * (m_i + 1); m++)
            s += filt(m);
        if (s > 64'sd8388607) s = 64'sd8388607;
        if (s < -64'sd8388608) s = -64'sd8388608;
        v = s[23:0];
        return {v, 5'b0, 3'(m_ch)};
    endfunction

    // check the previous edge, then drive the next cycle
    task automatic step(input bit v, input bit b, input bit ack);
        @(negedge clk);
        check(eoc == exp_eoc, {tag, "/R8"}, "eoc", eoc, exp_eoc);
        if (exp_eoc)
            check(out_word == exp_word, {tag, "/R6"}, "out_word",
                  longint'(out_word), longint'(exp_word));
        check(ovr == m_ovr, {tag, "/R9"}, "ovr", ovr, m_ovr);
        bit_vld = v;
        bit_in  = b;
        rd_ack  = ack;
        exp_eoc = 1'b0;
        if (v && cfg_en) begin
            xs.push_back(b ? 1 : -1);
            kbits++;
            if (kbits % (m_r * (m_i + 1)) == 0) begin
                nres++;
                exp_eoc  = 1'b1;
                exp_word = exp_result(nres);
                if (m_pend && !ack) m_ovr = 1'b1;
                m_pend = 1'b1;
            end else begin
                m_pend = m_pend && !ack;
            end
        end else begin
            m_pend = m_pend && !ack && cfg_en;
        end
    endtask

    task automatic configure(input int code, input int f, input int i, input int ch);
        step(1'b0, 1'b0, 1'b1);
        cfg_en    = 1'b0;
        cfg_order = 3'(code);
        cfg_fosr  = 10'(f);
        cfg_iosr  = 8'(i);
        cfg_chan  = 3'(ch);
        m_pend    = 1'b0;
        step(1'b0, 1'b0, 1'b1);
        cfg_en = 1'b1;
        m_r = f + 1;
        m_i = i;
        m_ch = ch;
        kbits = 0;
        nres = 0;
        xs.delete();
        build_kernel(eff_order(code), m_r);
    endtask

    // dmode: 0 random, 1 all ones, 2 all zeros
    task automatic feed(input int nbits, input int dmode, input int gap_pct, input bit ack);
        int got = 0;
        while (got < nbits) begin
            bit v = ($urandom % 100) >= gap_pct;
            bit b = (dmode == 0) ? bit'($urandom % 2) : (dmode == 1);
            step(v, b, ack);
            if (v) got++;
        end
        step(1'b0, 1'b0, ack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd9137));
        rst_n = 1'b0; cfg_en = 1'b0; cfg_order = '0; cfg_fosr = '0; cfg_iosr = '0;
        cfg_chan = '0; bit_vld = 1'b0; bit_in = 1'b0; rd_ack = 1'b0; ovr_clr = 1'b0;
        exp_eoc = 1'b0; m_ovr = 1'b0; m_pend = 1'b0; m_r = 1; m_i = 0; tag = "R1";
        repeat (4) @(negedge clk);
        // R1: reset values
        check(out_word == '0, "R1", "out_word", longint'(out_word), 0);
        check(eoc == 1'b0, "R1", "eoc", eoc, 0);
        check(ovr == 1'b0, "R1", "ovr", ovr, 0);
        rst_n = 1'b1;

        // R2: first order, gapped random bits
        tag = "R2";
        configure(1, 3, 0, 5);
        feed(40, 0, 30, 1'b1);

        // R3: every order code with random ratios and tags
        tag = "R3";
        for (int code = 0; code < 8; code++) begin
            int f = 1 + int'($urandom % 7);
            int i = int'($urandom % 3);
            configure(code, f, i, int'($urandom % 8));
            feed((f + 1) * (i + 1) * (eff_order(code) + 2), 0, 25, 1'b1);
        end

        // R4: longer integrator
        tag = "R4";
        configure(2, 4, 5, 1);
        feed(120, 0, 0, 1'b1);

        // R7: clamp in both directions
        tag = "R7";
        configure(5, 15, 15, 7);
        feed(512, 1, 0, 1'b1);
        configure(5, 15, 15, 6);
        feed(512, 2, 0, 1'b1);

        // R9: two results without acknowledgement
        tag = "R9";
        configure(1, 1, 0, 2);
        feed(4, 1, 0, 1'b0);
        // R10: flag held, then cleared
        tag = "R10";
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        check(ovr == 1'b1, "R10", "ovr held", ovr, 1);
        ovr_clr = 1'b1;
        m_ovr = 1'b0;
        step(1'b0, 1'b0, 1'b1);
        ovr_clr = 1'b0;
        step(1'b0, 1'b0, 1'b1);

        // R11: partial run, disable with activity, restart clean
        tag = "R11";
        configure(3, 3, 1, 4);
        feed(5, 0, 0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        cfg_en = 1'b0;
        m_pend = 1'b0;
        for (int c = 0; c < 6; c++) step(1'b1, 1'b1, 1'b1);
        configure(3, 3, 1, 4);
        feed(48, 0, 20, 1'b1);

        // R5: sparse strobes with toggling idle data
        tag = "R5";
        configure(2, 2, 0, 3);
        feed(30, 0, 60, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule